// File: doc/BRIEF.md
# Programmable Delay Line with Latched Code

This block delays a single-bit signal by a whole number of sample-clock cycles. The cycles are chosen by a binary code. Each cycle stands for one delay unit. The signal always crosses a fixed pipeline of `MIN_LAT` flops. After that it meets one stage per code bit. Bit k inserts a shift register of 2^k flops, and a cleared bit bypasses that stage through a 2:1 select. Every stage shifts on every clock whether it is selected or not. A code change therefore never empties an inserted stage, but the output needs one full chain length to settle after the change. The last stage is followed by a gate that can force the output low.

The code, together with one extra cascade bit, passes through a code register with a level hold control. While the hold control is low, the register is transparent. While the hold control is high, the register keeps the code it last saw. Two override inputs act directly on the stored code:
- Force-minimum clears the stored code.
- Force-maximum fills the stored code with ones and also inserts one extra single-unit stage.

The cascade bit drives a complementary output pair. This pair lets a following delay line be set to its minimum or maximum. Typical uses are skew trimming between channels and sweeping a strobe edge to measure an unknown delay.

Top module: `prog_delay_line`

## Requirements
- R1: With no override active, the delay from `din` to `dout` is `MIN_LAT` plus the sum of 2^k over every set bit k of the effective code (`code_in[CODE_W-1:0]`, bit 0 weighs 1 unit). A value sampled at clock edge p appears on `dout` after edge p+`MIN_LAT`+units-1, once the chain has settled.
- R2: While `hold` is low, the effective code and the cascade pair follow `code_in` in the same cycle.
- R3: While `hold` is high, the code stored at the last clock edge with `hold` low stays in effect. Changes on `code_in`, the cascade bit `code_in[CODE_W]` included, have no effect on the delay or on the cascade pair.
- R4: While `force_min` is high, the programmed delay is 0 units and `casc_p` is low, whatever `code_in` and `hold` are.
- R5: While `force_max` is high and `force_min` is low, the programmed delay is 2^`CODE_W` units. This is one unit more than the all-ones code gives. `casc_p` is high.
- R6: `force_min` has priority over `force_max` when both are high.
- R7: The overrides rewrite the stored code. After `force_min` (or `force_max` alone) is released while `hold` is high, the stored code is all zeros (or all ones, giving 2^`CODE_W`-1 units without the extra stage).
- R8: While `out_block` is high, `dout` is low. When `out_block` goes low, the delayed signal reappears at once, with no pipeline state lost.
- R9: `casc_p` equals the effective cascade bit and `casc_n` is always its complement.
- R10: During and right after reset, the stored code is zero, every stage holds zero, `dout` is low, `casc_p` is low and `casc_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one period is one delay unit |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to be delayed |
| out_block | input | 1 | High forces `dout` low |
| hold | input | 1 | Low: code register transparent; high: code frozen |
| force_min | input | 1 | Override to minimum delay; clears stored code |
| force_max | input | 1 | Override to maximum delay; fills stored code |
| code_in | input | CODE_W+1 | Delay code in bits CODE_W-1..0, cascade bit at CODE_W |
| dout | output | 1 | Delayed, gated signal |
| casc_p | output | 1 | Cascade output, true polarity |
| casc_n | output | 1 | Cascade output, complement |

## Verification
The bench builds the block with its defaults: `CODE_W` = 10 and `MIN_LAT` = 4. This makes the full 1024-unit forced maximum reachable, and the 512-unit stage is exercised together with the smallest stages. The short fixed pipeline keeps the settle window after each code change near 1,030 cycles. This leaves room for many configurations, among them the single step from code all-ones to the forced maximum. Pulse trains with random run lengths are mixed with uniformly random bits. A mismatch at any delay offset therefore shows up as a wrong bit, not as a coincidental match.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Units of delay selected by a binary code plus the optional extra unit.
  function automatic int unsigned pdl_units(input logic [15:0] code, input logic extra);
    int unsigned acc;
    acc = 0;
    for (int k = 0; k < 16; k++) begin
      if (code[k]) acc = acc + (32'd1 << k);
    end
    return acc + (extra ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/pdl_stage.sv
module pdl_stage #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel,
  output logic dout
);
  logic [LEN-1:0] sr;

  generate
    if (LEN == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LEN-2:0], din};
      end
    end
  endgenerate

  assign dout = sel ? sr[LEN-1] : din;
endmodule

// File: rtl/pdl_code_reg.sv
module pdl_code_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         force_min,
  input  logic         force_max,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] code_eff,
  output logic         extra
);
  logic [W-1:0] held_q;
  logic         max_mode;

  assign max_mode = force_max & ~force_min;

  always_ff @(posedge clk) begin
    if (rst)            held_q <= '0;
    else if (force_min) held_q <= '0;
    else if (force_max) held_q <= '1;
    else if (!hold)     held_q <= d_in;
  end

  always_comb begin
    if (force_min)      code_eff = '0;
    else if (force_max) code_eff = '1;
    else if (hold)      code_eff = held_q;
    else                code_eff = d_in;
  end

  assign extra = max_mode;

  // R3: stored code cannot move while held and no override acted
  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(hold) && !$past(force_min) && !$past(force_max)) |-> $stable(held_q));
  // R7: minimum override leaves the store cleared
  p_fmin_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(force_min) |-> (held_q == '0));
  // R7: maximum override alone leaves the store filled
  p_fmax_fill_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(force_max) && !$past(force_min)) |-> (&held_q));
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int CODE_W  = 10,
  parameter int MIN_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              out_block,
  input  logic              hold,
  input  logic              force_min,
  input  logic              force_max,
  input  logic [CODE_W:0]   code_in,
  output logic              dout,
  output logic              casc_p,
  output logic              casc_n
);
  import pdl_pkg::*;

  localparam int          CW        = CODE_W + 1;
  localparam int unsigned MAX_UNITS = 32'd1 << CODE_W;

  logic [CW-1:0]     code_eff;
  logic              extra;
  logic [CODE_W+1:0] link;
  logic              fixed_out;
  logic              chain_out;
  int unsigned       units_now;

  pdl_code_reg #(.W(CW)) u_code (
    .clk(clk), .rst(rst), .hold(hold),
    .force_min(force_min), .force_max(force_max),
    .d_in(code_in), .code_eff(code_eff), .extra(extra)
  );

  // Fixed minimum latency, always inserted
  pdl_stage #(.LEN(MIN_LAT)) u_fixed (
    .clk(clk), .rst(rst), .din(din), .sel(1'b1), .dout(fixed_out)
  );

  assign link[0] = fixed_out;

  // Extra one-unit stage, used only in forced-maximum mode
  pdl_stage #(.LEN(1)) u_extra (
    .clk(clk), .rst(rst), .din(link[0]), .sel(extra), .dout(link[1])
  );

  // Binary-weighted stages, heaviest first
  generate
    for (genvar i = 0; i < CODE_W; i++) begin : g_bin
      localparam int BIT = CODE_W - 1 - i;
      pdl_stage #(.LEN(1 << BIT)) u_st (
        .clk(clk), .rst(rst), .din(link[i+1]),
        .sel(code_eff[BIT]), .dout(link[i+2])
      );
    end
  endgenerate

  assign chain_out = link[CODE_W+1];
  assign dout      = chain_out & ~out_block;
  assign casc_p    = code_eff[CODE_W];
  assign casc_n    = ~code_eff[CODE_W];

  assign units_now = pdl_units(16'(code_eff[CODE_W-1:0]), extra);

  // R4: minimum override gives zero units and low cascade
  p_fmin_zero_r4: assert property (@(posedge clk) disable iff (rst)
    force_min |-> (units_now == 0 && !casc_p));
  // R5: maximum override gives full range plus one unit
  p_fmax_full_r5: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |-> (units_now == MAX_UNITS && casc_p));
  // R2: transparent cascade bit
  p_casc_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && !force_min && !force_max) |-> (casc_p == code_in[CODE_W]));
  // R8: gated output stays low
  p_block_low_r8: assert property (@(posedge clk) disable iff (rst)
    out_block |-> !dout);
endmodule

// File: tb/sim_prog_delay_line.sv
`timescale 1ns/1ps
module sim_prog_delay_line;
  localparam int CODE_W  = 10;
  localparam int MIN_LAT = 4;
  localparam int SETTLE  = MIN_LAT + (1 << CODE_W) + 8;
  localparam int NCHK    = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic out_block = 1'b0;
  logic hold = 1'b0;
  logic force_min = 1'b0;
  logic force_max = 1'b0;
  logic [CODE_W:0] code_in = '0;
  logic dout, casc_p, casc_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;
  logic hist [0:4095];
  int run_left = 0;
  logic level = 1'b0;
  bit rand_mode = 1'b0;
  int bad;
  logic bad_act, bad_exp;

  always #2.5 clk = ~clk;

  prog_delay_line #(.CODE_W(CODE_W), .MIN_LAT(MIN_LAT)) u0 (
    .clk(clk), .rst(rst), .din(din), .out_block(out_block), .hold(hold),
    .force_min(force_min), .force_max(force_max), .code_in(code_in),
    .dout(dout), .casc_p(casc_p), .casc_n(casc_n)
  );

  function automatic int exp_units(input logic [CODE_W-1:0] c);
    int s = 0;
    for (int k = 0; k < CODE_W; k++) if (c[k]) s += (1 << k);
    return s;
  endfunction

  // One cycle: compare at the negedge, then drive the next input bit.
  task automatic step(input bit chk, input int lat, input bit blocked);
    logic e;
    @(negedge clk);
    if (chk) begin
      e = blocked ? 1'b0 : hist[(cyc - lat) & 4095];
      if (dout !== e) begin
        if (bad == 0) begin bad_act = dout; bad_exp = e; end
        bad++;
      end
    end
    if (rand_mode) din = 1'($urandom_range(0, 1));
    else begin
      if (run_left == 0) begin level = ~level; run_left = $urandom_range(1, 9); end
      run_left--;
      din = level;
    end
    hist[cyc & 4095] = din;
    cyc++;
  endtask

  task automatic check_delay(input int units, input string tag, input bit do_settle);
    if (do_settle) repeat (SETTLE) step(1'b0, 0, 1'b0);
    bad = 0;
    for (int i = 0; i < NCHK; i++) step(1'b1, MIN_LAT + units, 1'b0);
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: delay %0d units, %0d mismatches, actual %0b expected %0b",
               tag, units, bad, bad_act, bad_exp);
    end
    rand_mode = ~rand_mode;
  endtask

  task automatic check_casc(input logic exp_p, input string tag);
    tests++;
    if (casc_p !== exp_p || casc_n !== ~exp_p) begin
      fails++;
      $display("FAIL %s: cascade actual %0b/%0b expected %0b/%0b",
               tag, casc_p, casc_n, exp_p, ~exp_p);
    end
  endtask

  initial begin
    logic [CODE_W:0] lockc;
    for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    tests++;
    if (dout !== 1'b0 || casc_p !== 1'b0 || casc_n !== 1'b1) begin
      fails++;
      $display("FAIL R10: reset outputs actual %0b%0b%0b expected 001", dout, casc_p, casc_n);
    end
    rst = 1'b0;
    @(negedge clk);
    check_casc(1'b0, "R10");
    // R10: all stages hold zero, so output stays low with idle input and zero code
    tests++;
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (dout !== 1'b0) bad++; end
    if (bad != 0) begin fails++; $display("FAIL R10: dout actual 1 expected 0"); end

    // R1/R2: transparent code, zero and all-ones and single weights
    code_in = '0;                      check_delay(0, "R1 zero", 1);
    code_in = {1'b0, {CODE_W{1'b1}}};  check_delay(exp_units('1), "R1 all-ones", 1);
    code_in = 11'h001;                 check_delay(1, "R1 bit0", 1);
    code_in = 11'h020;                 check_delay(32, "R1 bit5", 1);
    code_in = 11'h200;                 check_delay(512, "R1 bit9", 1);
    for (int r = 0; r < 4; r++) begin
      code_in = 11'($urandom_range(0, 2047));
      check_delay(exp_units(code_in[CODE_W-1:0]), "R1 random", 1);
      check_casc(code_in[CODE_W], "R2 cascade follows");
    end
    // R9: cascade bit set and clear
    code_in = 11'h400; @(negedge clk); check_casc(1'b1, "R9 high");
    code_in = 11'h000; @(negedge clk); check_casc(1'b0, "R9 low");

    // R4: force minimum with arbitrary code
    code_in = 11'h7A5; force_min = 1'b1; @(negedge clk); check_casc(1'b0, "R4");
    check_delay(0, "R4 fmin", 1);
    force_min = 1'b0;
    // R5: force maximum, one more unit than all-ones
    code_in = 11'h013; force_max = 1'b1; @(negedge clk); check_casc(1'b1, "R5");
    check_delay(1 << CODE_W, "R5 fmax", 1);
    // R6: both forces
    force_min = 1'b1; @(negedge clk); check_casc(1'b0, "R6");
    check_delay(0, "R6 both", 1);
    force_min = 1'b0; force_max = 1'b0;

    // R3: lock then change code_in
    lockc = 11'h4C7;
    code_in = lockc; repeat (3) step(1'b0, 0, 1'b0);
    hold = 1'b1; step(1'b0, 0, 1'b0);
    code_in = 11'h038;
    check_delay(exp_units(lockc[CODE_W-1:0]), "R3 locked", 1);
    check_casc(1'b1, "R3 cascade locked");
    code_in = 11'h3FF; @(negedge clk); check_casc(1'b1, "R3 cascade ignores");
    check_delay(exp_units(lockc[CODE_W-1:0]), "R3 still locked", 1);

    // R7: overrides rewrite the store under hold
    force_min = 1'b1; repeat (2) step(1'b0, 0, 1'b0); force_min = 1'b0;
    check_delay(0, "R7 cleared", 1);
    check_casc(1'b0, "R7 cleared cascade");
    force_max = 1'b1; repeat (2) step(1'b0, 0, 1'b0); force_max = 1'b0;
    check_delay(exp_units('1), "R7 filled", 1);
    check_casc(1'b1, "R7 filled cascade");

    // R2: releasing hold returns to transparency
    hold = 1'b0; code_in = 11'h055;
    check_delay(exp_units(10'h055), "R2 release", 1);

    // R8: output gate
    out_block = 1'b1;
    bad = 0;
    for (int i = 0; i < 64; i++) step(1'b1, 0, 1'b1);
    tests++;
    if (bad != 0) begin fails++; $display("FAIL R8: blocked dout actual 1 expected 0"); end
    out_block = 1'b0;
    check_delay(exp_units(10'h055), "R8 resume", 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule